// File: doc/BRIEF.md
# Clocked Programmable Tapped Delay Line

The block copies a one-bit input to its output, without inversion, a programmed number of clock cycles later. The delay comes from a chain of identical one-cycle stages. An address of `ADDR_W` bits picks which stage drives the output. A short fixed pipeline ahead of the chain adds an inherent offset of `INHERENT` cycles to every setting. The total delay is therefore `INHERENT + address` cycles, with 256 equal steps at the default width.

A new address is written with a one-cycle strobe and then held as pending. The block applies it only after the input has stayed at one level long enough for every stage of the line to hold that same level. At that point all taps agree, so moving the output multiplexer cannot produce a false edge. A delay-valid flag goes low when a new address is requested. It comes back high a fixed number of settle cycles after the tap actually moves.

Top module: `tdl_delay_line`

## Requirements
- R1: During and right after synchronous reset (`rst` high), every stage holds 0, `dout` is 0, `dly_valid` is 1 and the applied address is 0 (delay of `INHERENT` cycles).
- R2: With address A applied, the `din` value sampled at rising edge n appears on `dout` after edge n + `INHERENT` + A. Rising and falling edges are delayed alike and the output is not inverted.
- R3: Every address from 0 to 2^`ADDR_W` − 1 is usable. Address 255 gives the longest delay, `INHERENT` + 255 cycles.
- R4: A cycle with `addr_stb` high captures `addr_in` as a pending address. The applied delay does not change while `din` keeps changing.
- R5: The pending address is applied at the first edge whose preceding `2^ADDR_W + INHERENT + 1` samples of `din` were all equal. Reset counts as a fully idle history for this purpose.
- R6: `dout` does not change on the edge where the applied address changes.
- R7: `dly_valid` is 0 from the edge that samples `addr_stb` high until the settle interval of R9 ends.
- R8: A later strobe replaces the pending address; the last one wins. A strobe on the edge where a switch would happen, or during the settle interval, restarts the wait for idle using the new address.
- R9: `dly_valid` becomes 1 exactly `SETTLE` edges after the switch edge, provided no new strobe arrives in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one delay step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Data to be delayed |
| addr_in | input | ADDR_W | Requested delay step |
| addr_stb | input | 1 | One-cycle strobe that captures `addr_in` |
| dout | output | 1 | Delayed copy of `din` |
| dly_valid | output | 1 | High when the applied delay is settled |

## Verification
The line is driven with random pulse trains whose run lengths vary from one cycle up to dozens of cycles. This separates an off-by-one tap error from a polarity or inversion error, and shows that both edges are delayed alike. Directed cases cover the extreme addresses 0 and 255, and an address request made while the input keeps toggling, which shows that the switch is held off until the input goes idle. They also cover back-to-back requests and requests made during settling, which separate the last-wins behaviour and the restart of the wait from a switch that happens too early. An isolated pulse placed just before an address change shows any false edge at the moment of the switch.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Phase of the tap-switch controller
    typedef enum logic [1:0] {
        SW_STEADY    = 2'd0,   // applied delay settled
        SW_WAIT_IDLE = 2'd1,   // request pending, waiting for a quiet line
        SW_SETTLE    = 2'd2    // tap moved, counting settle cycles
    } sw_state_e;

    // Number of bits needed to hold values 0..maxv
    function automatic int unsigned cnt_bits(input int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    // Saturating increment for an idle counter
    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/tdl_tap_chain.sv
module tdl_tap_chain #(
    parameter int ADDR_W   = 8,
    parameter int INHERENT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] sel,
    output logic              dout
);
    localparam int TAPS = 1 << ADDR_W;

    logic [INHERENT-1:0] pre_q;
    logic [TAPS-1:0]     tap_q;

    // Fixed offset stages ahead of the selectable chain
    generate
        for (genvar gp = 0; gp < INHERENT; gp++) begin : g_pre
            if (gp == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pre_q[0] <= 1'b0;
                    else     pre_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pre_q[gp] <= 1'b0;
                    else     pre_q[gp] <= pre_q[gp-1];
                end
            end
        end
    endgenerate

    // Selectable chain: tap k is one stage later than tap k-1
    always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= {tap_q[TAPS-2:0], pre_q[INHERENT-1]};
    end

    assign dout = tap_q[sel];

    // R2: the first selectable stage follows the offset pipeline by one cycle
    assert_first_tap_follows_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (tap_q[0] == $past(pre_q[INHERENT-1])));

endmodule

// File: rtl/tdl_idle_watch.sv
module tdl_idle_watch #(
    parameter int LIMIT = 258
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic idle_full
);
    import tdl_pkg::*;

    localparam int CW = cnt_bits(LIMIT);

    logic          last_q;
    logic [CW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
            idle_q <= CW'(LIMIT);
        end else begin
            last_q <= din;
            if (din != last_q) idle_q <= '0;
            else               idle_q <= CW'(sat_inc(int'(idle_q), LIMIT));
        end
    end

    assign idle_full = (idle_q == CW'(LIMIT));

    // R5: a non-zero idle count means the input did not move on the last edge
    assert_idle_means_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && idle_q != '0) |-> $stable(last_q));

endmodule

// File: rtl/tdl_tap_switch.sv
module tdl_tap_switch #(
    parameter int ADDR_W = 8,
    parameter int SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_stb,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              idle_full,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              dly_valid
);
    import tdl_pkg::*;

    localparam int SCW = cnt_bits(SETTLE);

    sw_state_e         state_q;
    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] cur_q;
    logic [SCW-1:0]    scnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_STEADY;
            pend_q  <= '0;
            cur_q   <= '0;
            scnt_q  <= '0;
        end else if (addr_stb) begin
            // newest request always wins and restarts the wait
            pend_q  <= addr_in;
            state_q <= SW_WAIT_IDLE;
        end else begin
            unique case (state_q)
                SW_WAIT_IDLE: begin
                    if (idle_full) begin
                        cur_q   <= pend_q;
                        scnt_q  <= SCW'(1);
                        state_q <= SW_SETTLE;
                    end
                end
                SW_SETTLE: begin
                    if (scnt_q == SCW'(SETTLE)) state_q <= SW_STEADY;
                    else                        scnt_q  <= scnt_q + SCW'(1);
                end
                default: ;
            endcase
        end
    end

    assign cur_addr  = cur_q;
    assign dly_valid = (state_q == SW_STEADY);

    // R7: a sampled request drops the valid flag on the next cycle
    assert_stb_drops_valid_R7: assert property (@(posedge clk) disable iff (rst)
        addr_stb |=> !dly_valid);

    // R9: valid only returns from the settle phase
    assert_valid_after_settle_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dly_valid) |-> ($past(state_q) == SW_SETTLE && $past(!addr_stb)));

endmodule

// File: rtl/tdl_delay_line.sv
module tdl_delay_line #(
    parameter int ADDR_W   = 8,
    parameter int INHERENT = 2,
    parameter int SETTLE   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_stb,
    output logic              dout,
    output logic              dly_valid
);
    localparam int TAPS       = 1 << ADDR_W;
    localparam int IDLE_LIMIT = TAPS + INHERENT;

    logic              idle_full;
    logic [ADDR_W-1:0] cur_addr;

    tdl_tap_chain #(.ADDR_W(ADDR_W), .INHERENT(INHERENT)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .sel  (cur_addr),
        .dout (dout)
    );

    tdl_idle_watch #(.LIMIT(IDLE_LIMIT)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .idle_full (idle_full)
    );

    tdl_tap_switch #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) u_switch (
        .clk       (clk),
        .rst       (rst),
        .addr_stb  (addr_stb),
        .addr_in   (addr_in),
        .idle_full (idle_full),
        .cur_addr  (cur_addr),
        .dly_valid (dly_valid)
    );

    // R5: the tap only moves after a fully quiet line
    assert_switch_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_addr != $past(cur_addr)) |-> $past(idle_full));

    // R6: no output transition on the switch edge
    assert_no_glitch_on_switch_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_addr != $past(cur_addr)) |-> (dout == $past(dout)));

endmodule

// File: tb/tdl_delay_line_bench.sv
module tdl_delay_line_bench;

    localparam int ADDR_W = 8;
    localparam int INH    = 2;
    localparam int SETTLE = 4;
    localparam int TAPS   = 1 << ADDR_W;
    localparam int LIMIT  = TAPS + INH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic addr_stb = 1'b0;
    logic dout;
    logic dly_valid;

    always #2 clk = ~clk;   // 250 MHz

    tdl_delay_line #(.ADDR_W(ADDR_W), .INHERENT(INH), .SETTLE(SETTLE)) u_tdl_delay_line (
        .clk(clk), .rst(rst), .din(din), .addr_in(addr_in),
        .addr_stb(addr_stb), .dout(dout), .dly_valid(dly_valid)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string tag = "R2";

    // Reference model built from the requirements
    logic hist [0:1023];
    int   e_idx = 1024;
    int   m_cur = 0, m_pend = 0, m_idle = LIMIT, m_scnt = 0, m_state = 0; // 0 steady 1 wait 2 settle
    int   since_sw = 0;
    logic m_last = 1'b0;
    logic prev_dout = 1'b0;

    task automatic check(input string rq, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic logic model_out(input int cur);
        return hist[(e_idx - INH - cur) & 1023];
    endfunction

    task automatic tick(input logic d, input logic s, input logic [ADDR_W-1:0] a);
        bit full;
        int old_cur;
        din = d; addr_stb = s; addr_in = a;
        @(posedge clk); #1;
        full = (m_idle == LIMIT);
        old_cur = m_cur;
        if (s) begin
            m_pend = a; m_state = 1;
        end else if (m_state == 1 && full) begin
            m_cur = m_pend; m_state = 2; m_scnt = 1; since_sw = 0;
        end else if (m_state == 2) begin
            if (m_scnt == SETTLE) m_state = 0; else m_scnt++;
        end
        if (m_state == 2 || m_cur != old_cur) since_sw++;
        if (d != m_last) m_idle = 0; else if (m_idle < LIMIT) m_idle++;
        m_last = d;
        e_idx++;
        hist[e_idx & 1023] = d;
        check(tag, dout, model_out(m_cur), "dout");
        check("R7", dly_valid, (m_state == 0), "dly_valid");
        if (m_cur != old_cur) check("R6", dout, prev_dout, "dout at switch edge");
        if (m_state == 0 && dly_valid && since_sw != 0) begin
            checks++;
            if (since_sw != SETTLE) begin
                failures++;
                $display("FAIL R9 settle edges actual=%0d expected=%0d", since_sw, SETTLE);
            end
            since_sw = 0;
        end
        prev_dout = dout;
    endtask

    task automatic set_addr(input logic lvl, input logic [ADDR_W-1:0] a);
        tick(lvl, 1'b1, a);
        for (int k = 0; k < LIMIT + SETTLE + 8 && !dly_valid; k++) tick(lvl, 1'b0, a);
    endtask

    task automatic traffic(input int n, input int maxw);
        logic lvl = din;
        int run = 0;
        for (int k = 0; k < n; k++) begin
            if (run == 0) begin lvl = ~lvl; run = 1 + ($urandom % maxw); end
            tick(lvl, 1'b0, '0);
            run--;
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        check("R1", dout, 1'b0, "dout after reset");
        check("R1", dly_valid, 1'b1, "dly_valid after reset");

        tag = "R1"; traffic(40, 6);                   // address 0 delay
        tag = "R2"; traffic(200, 12);

        tag = "R3"; set_addr(din, 8'd255);            // longest delay
        tick(~din, 1'b0, '0); tick(din, 1'b0, '0);    // isolated pulse
        traffic(600, 20);
        tag = "R3"; set_addr(din, 8'd0);
        traffic(60, 4);

        tag = "R4";                                   // request while toggling
        tick(~din, 1'b1, 8'd9);
        traffic(150, 3);
        check("R4", dly_valid, 1'b0, "still pending while busy");
        tag = "R5";
        for (int k = 0; k < LIMIT + SETTLE + 8; k++) tick(din, 1'b0, '0);
        traffic(100, 15);

        tag = "R8";                                   // back-to-back, last wins
        tick(din, 1'b1, 8'd3); tick(din, 1'b1, 8'd40);
        for (int k = 0; k < LIMIT + 2; k++) tick(din, 1'b0, '0);
        tick(din, 1'b1, 8'd17);                       // during settle
        for (int k = 0; k < LIMIT + SETTLE + 8; k++) tick(din, 1'b0, '0);
        traffic(120, 10);

        tag = "R9";
        for (int it = 0; it < 20; it++) begin
            set_addr(din, ADDR_W'($urandom % TAPS));
            traffic(150 + ($urandom % 150), 1 + ($urandom % 25));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule